// File: doc/BRIEF.md
# Bayer Channel Gain and Offset Stage

This block sits in a raw image pipeline directly after the sensor converter. It receives a valid-qualified stream of 10-bit raw samples with a start-of-frame marker on the first pixel and an end-of-line marker on the last pixel of each line. The samples form a 2x2 colour mosaic. The block works out which of the four colour channels (red, green-on-red-row, green-on-blue-row, blue) each sample belongs to. It then scales the sample by that channel's reciprocal-law gain, adds that channel's signed offset, clamps the result to the 10-bit range and, if asked, reduces the output precision by zeroing low bits.

Configuration arrives on plain input ports: a 7-bit gain code and an 8-bit signed offset per channel, a channel-separation enable and a 2-bit resolution select. These values are captured only on the start-of-frame pixel, so every frame uses one consistent setting. When separation is off, the settings of the green-on-red-row channel apply to every pixel. The stream leaves the block after a fixed latency, and its markers stay aligned with the data.

Top module: `bayer_gain_stage`

## Requirements
- R1: Each pixel's channel follows row and column parity. The start-of-frame pixel is row 0, column 0. Every valid pixel flips the column parity, and a valid end-of-line pixel instead resets the column to 0 and flips the row. Row 0 alternates red (column 0) and green-R (column 1). Row 1 alternates green-B (column 0) and blue (column 1).
- R2: When cfg_sep_en is 0, the green-R gain code and offset are applied to every pixel regardless of its position.
- R3: The gained value is floor(pixel*128/(128-code)) for the 7-bit code. Code 0 returns the pixel unchanged, code 64 doubles it, and code 127 multiplies it by 128.
- R4: The offset is an 8-bit two's-complement value added after the gain. The sum saturates to 0 when negative and to 1023 when above 1023.
- R5: cfg_res encodes 0 as full 10 bits, 1 as 9 bits (out_pix bit 0 forced to 0) and 2 as 8 bits (out_pix bits 1:0 forced to 0). Code 3 behaves as full 10 bits. The masking is applied after saturation.
- R6: All configuration ports are captured on the valid start-of-frame pixel, and that pixel already uses the new values. Changes at any other time have no effect on the output until the next start of frame.
- R7: out_valid, out_sof, out_eol and out_pix appear exactly 3 clock cycles after the input pixel. Markers are only output together with out_valid, and out_pix is 0 whenever out_valid is 0.
- R8: While in reset, all outputs are 0. After reset, and until the first start of frame, the captured settings are gains 0, offsets 0, separation enabled and full resolution, so pixels pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame (with in_valid) |
| in_eol | input | 1 | Last pixel of a line (with in_valid) |
| in_pix | input | 10 | Raw sample |
| cfg_gain_r | input | 7 | Gain code, red |
| cfg_gain_gr | input | 7 | Gain code, green on red row |
| cfg_gain_gb | input | 7 | Gain code, green on blue row |
| cfg_gain_b | input | 7 | Gain code, blue |
| cfg_ofs_r | input | 8 | Signed offset, red |
| cfg_ofs_gr | input | 8 | Signed offset, green on red row |
| cfg_ofs_gb | input | 8 | Signed offset, green on blue row |
| cfg_ofs_b | input | 8 | Signed offset, blue |
| cfg_sep_en | input | 1 | 1 selects per-channel settings, 0 selects green-R settings for all |
| cfg_res | input | 2 | Output precision select |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_eol | output | 1 | Delayed end-of-line marker |
| out_pix | output | 10 | Processed sample |

## Verification
The bench builds the block with its default parameters: 10-bit pixels, 7-bit gain codes, 8-bit offsets and a reciprocal with 10 fraction bits. Ten fraction bits is the smallest value that keeps the estimate within one of the true quotient for 10-bit pixels. With that value the one-step quotient correction fires on a large share of pixel and code pairs, so the random frames test the correction heavily, not only in rare cases. The full code range from 0 to 127 is reachable together with full-scale pixels, so both the multiply-by-128 extreme and upper saturation are covered.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
    typedef enum logic [1:0] {
        CH_R  = 2'd0,
        CH_GR = 2'd1,
        CH_GB = 2'd2,
        CH_B  = 2'd3
    } chan_e;

    typedef enum logic [1:0] {
        RES_FULL = 2'd0,
        RES_9B   = 2'd1,
        RES_8B   = 2'd2,
        RES_ALT  = 2'd3
    } res_e;
endpackage

// File: rtl/bgs_cfg_shadow.sv
module bgs_cfg_shadow #(
    parameter int GAIN_W = 7,
    parameter int OFS_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [3:0][GAIN_W-1:0]      gain_in,
    input  logic [3:0][OFS_W-1:0]       ofs_in,
    input  logic                        sep_in,
    input  logic [1:0]                  res_in,
    output logic [3:0][GAIN_W-1:0]      gain_eff,
    output logic [3:0][OFS_W-1:0]       ofs_eff,
    output logic                        sep_eff,
    output logic [1:0]                  res_eff
);
    typedef struct packed {
        logic [3:0][GAIN_W-1:0] gain;
        logic [3:0][OFS_W-1:0]  ofs;
        logic                   sep;
        logic [1:0]             res;
    } cfg_t;

    localparam cfg_t CFG_RST = '{gain: '0, ofs: '0, sep: 1'b1, res: 2'd0};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.gain = gain_in;
            cfg_d.ofs  = ofs_in;
            cfg_d.sep  = sep_in;
            cfg_d.res  = res_in;
        end
        // the start-of-frame pixel already sees the fresh settings
        gain_eff = load ? gain_in : cfg_q.gain;
        ofs_eff  = load ? ofs_in  : cfg_q.ofs;
        sep_eff  = load ? sep_in  : cfg_q.sep;
        res_eff  = load ? res_in  : cfg_q.res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    // R6: captured settings only move on a start-of-frame pixel
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_q));
endmodule

// File: rtl/bgs_chan_tracker.sv
module bgs_chan_tracker
    import bgs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_sof,
    input  logic  in_eol,
    output chan_e chan
);
    typedef struct packed {
        logic row;
        logic col;
    } par_t;

    par_t par_d, par_q;
    logic row_now, col_now;

    always_comb begin
        par_d   = par_q;
        row_now = in_sof ? 1'b0 : par_q.row;
        col_now = in_sof ? 1'b0 : par_q.col;
        chan    = chan_e'({row_now, col_now});
        if (in_valid) begin
            if (in_eol) begin
                par_d.row = ~row_now;
                par_d.col = 1'b0;
            end else begin
                par_d.row = row_now;
                par_d.col = ~col_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    // R1: a frame's first pixel leaves the tracker on row 0, column 1
    assert_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eol) |=> (par_q.row == 1'b0 && par_q.col == 1'b1));
    // R1: a line end returns to column 0 on the other row
    assert_line_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eol && !in_sof) |=> (par_q.col == 1'b0 && par_q.row != $past(par_q.row)));
endmodule

// File: rtl/bgs_gain_unit.sv
module bgs_gain_unit
    import bgs_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int GAIN_W = 7,
    parameter int OFS_W  = 8,
    parameter int FRAC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [GAIN_W-1:0] in_code,
    input  logic [OFS_W-1:0]  in_ofs,
    input  logic [1:0]        in_res,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eol,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int unsigned GAIN_ONE = 1 << GAIN_W;
    localparam int unsigned RECIP_NUM = 1 << (FRAC_W + GAIN_W);
    localparam int PROD_W  = PIX_W + GAIN_W;
    localparam int RECIP_W = FRAC_W + GAIN_W + 1;
    localparam int MUL_W   = PIX_W + RECIP_W;
    localparam int D_W     = GAIN_W + 1;
    localparam int CHK_W   = PROD_W + 1 + D_W;
    localparam int SUM_W   = PROD_W + 2;
    localparam logic [PIX_W-1:0] PIX_MAX = '1;

    typedef struct packed {
        logic              v;
        logic              sof;
        logic              eol;
        logic [PIX_W-1:0]  pix;
        logic [GAIN_W-1:0] code;
        logic [OFS_W-1:0]  ofs;
        logic [1:0]        res;
    } lane_t;

    typedef struct packed {
        lane_t             a;
        lane_t             b;
        logic [PROD_W-1:0] est;
        logic              ov;
        logic              osof;
        logic              oeol;
        logic [PIX_W-1:0]  opix;
    } pipe_t;

    pipe_t p_d, p_q;

    // scaled reciprocal, rounded down, one entry per gain code
    logic [RECIP_W-1:0] recip_tbl [GAIN_ONE];
    for (genvar gi = 0; gi < GAIN_ONE; gi++) begin : g_recip
        assign recip_tbl[gi] = RECIP_W'(RECIP_NUM / (GAIN_ONE - gi));
    end

    logic [MUL_W-1:0]        mul;
    logic [D_W-1:0]          den;
    logic [PROD_W:0]         q_try, q_fix;
    logic [CHK_W-1:0]        lhs, rhs;
    logic signed [SUM_W-1:0] sum;
    logic [PIX_W-1:0]        sat, trunc;

    always_comb begin
        p_d = p_q;

        // stage 1: capture the selected pixel and its settings
        p_d.a.v    = in_valid;
        p_d.a.sof  = in_valid & in_sof;
        p_d.a.eol  = in_valid & in_eol;
        p_d.a.pix  = in_pix;
        p_d.a.code = in_code;
        p_d.a.ofs  = in_ofs;
        p_d.a.res  = in_res;

        // stage 2: estimate the quotient with the reciprocal
        mul     = MUL_W'(p_q.a.pix) * MUL_W'(recip_tbl[p_q.a.code]);
        p_d.b   = p_q.a;
        p_d.est = PROD_W'(mul >> FRAC_W);

        // stage 3: single-step correction, offset, clamp, precision
        den   = D_W'(GAIN_ONE) - D_W'(p_q.b.code);
        q_try = {1'b0, p_q.est} + 1'b1;
        lhs   = CHK_W'(q_try) * CHK_W'(den);
        rhs   = CHK_W'({p_q.b.pix, {GAIN_W{1'b0}}});
        q_fix = (lhs <= rhs) ? q_try : {1'b0, p_q.est};
        sum   = $signed(SUM_W'(q_fix))
              + $signed({{(SUM_W-OFS_W){p_q.b.ofs[OFS_W-1]}}, p_q.b.ofs});
        if (sum[SUM_W-1])                sat = '0;
        else if (|sum[SUM_W-2:PIX_W])    sat = PIX_MAX;
        else                             sat = sum[PIX_W-1:0];
        case (res_e'(p_q.b.res))
            RES_9B:  trunc = sat & ~PIX_W'(1);
            RES_8B:  trunc = sat & ~PIX_W'(3);
            default: trunc = sat;
        endcase
        p_d.ov   = p_q.b.v;
        p_d.osof = p_q.b.sof;
        p_d.oeol = p_q.b.eol;
        p_d.opix = p_q.b.v ? trunc : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid = p_q.ov;
    assign out_sof   = p_q.osof;
    assign out_eol   = p_q.oeol;
    assign out_pix   = p_q.opix;

    // R3: code 0 leaves the corrected quotient equal to the pixel
    assert_unity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.b.v && p_q.b.code == '0) |-> (q_fix == (PROD_W+1)'(p_q.b.pix)));
    // R4: a zero product with a negative offset clamps to 0
    assert_floor_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.b.v && q_fix == '0 && p_q.b.ofs[OFS_W-1]) |=> (out_pix == '0));
    // R5: 8-bit precision leaves the two low bits clear
    assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.b.v && p_q.b.res == 2'd2) |=> (out_pix[1:0] == 2'b00));
endmodule

// File: rtl/bayer_gain_stage.sv
module bayer_gain_stage
    import bgs_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int GAIN_W = 7,
    parameter int OFS_W  = 8,
    parameter int FRAC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [GAIN_W-1:0] cfg_gain_r,
    input  logic [GAIN_W-1:0] cfg_gain_gr,
    input  logic [GAIN_W-1:0] cfg_gain_gb,
    input  logic [GAIN_W-1:0] cfg_gain_b,
    input  logic [OFS_W-1:0]  cfg_ofs_r,
    input  logic [OFS_W-1:0]  cfg_ofs_gr,
    input  logic [OFS_W-1:0]  cfg_ofs_gb,
    input  logic [OFS_W-1:0]  cfg_ofs_b,
    input  logic              cfg_sep_en,
    input  logic [1:0]        cfg_res,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eol,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int LAT = 3;

    logic [3:0][GAIN_W-1:0] gain_eff;
    logic [3:0][OFS_W-1:0]  ofs_eff;
    logic                   sep_eff;
    logic [1:0]             res_eff;
    chan_e                  chan;
    chan_e                  pick;
    logic [GAIN_W-1:0]      sel_code;
    logic [OFS_W-1:0]       sel_ofs;

    bgs_cfg_shadow #(.GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_valid & in_sof),
        .gain_in  ({cfg_gain_b, cfg_gain_gb, cfg_gain_gr, cfg_gain_r}),
        .ofs_in   ({cfg_ofs_b, cfg_ofs_gb, cfg_ofs_gr, cfg_ofs_r}),
        .sep_in   (cfg_sep_en),
        .res_in   (cfg_res),
        .gain_eff (gain_eff),
        .ofs_eff  (ofs_eff),
        .sep_eff  (sep_eff),
        .res_eff  (res_eff)
    );

    bgs_chan_tracker u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .chan     (chan)
    );

    always_comb begin
        pick     = sep_eff ? chan : CH_GR;
        sel_code = gain_eff[pick];
        sel_ofs  = ofs_eff[pick];
    end

    bgs_gain_unit #(
        .PIX_W(PIX_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .FRAC_W(FRAC_W)
    ) u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .in_pix    (in_pix),
        .in_code   (sel_code),
        .in_ofs    (sel_ofs),
        .in_res    (res_eff),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eol   (out_eol),
        .out_pix   (out_pix)
    );

    // cycles since reset, so latency checks never look before reset
    logic [1:0] warm_d, warm_q;
    always_comb warm_d = (warm_q == 2'(LAT)) ? warm_q : warm_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    // R7: the stream leaves exactly three cycles after it enters
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(LAT)) |-> (out_valid == $past(in_valid, 3)
                                 && out_sof == $past(in_valid && in_sof, 3)
                                 && out_eol == $past(in_valid && in_eol, 3)));
    // R7: markers and data only accompany a valid output
    assert_marker_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_sof && !out_eol && out_pix == '0));
endmodule

// File: tb/tb_bayer_gain_stage.sv
module tb_bayer_gain_stage;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       in_valid = 0, in_sof = 0, in_eol = 0;
    logic [9:0] in_pix = '0;
    logic [6:0] g_r = 0, g_gr = 0, g_gb = 0, g_b = 0;
    logic [7:0] o_r = 0, o_gr = 0, o_gb = 0, o_b = 0;
    logic       sep = 1'b1;
    logic [1:0] res = 2'd0;
    logic       out_valid, out_sof, out_eol;
    logic [9:0] out_pix;

    bayer_gain_stage dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_pix(in_pix),
        .cfg_gain_r(g_r), .cfg_gain_gr(g_gr), .cfg_gain_gb(g_gb), .cfg_gain_b(g_b),
        .cfg_ofs_r(o_r), .cfg_ofs_gr(o_gr), .cfg_ofs_gb(o_gb), .cfg_ofs_b(o_b),
        .cfg_sep_en(sep), .cfg_res(res),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
    );

    int total = 0, bad = 0;
    bit done = 0;
    int cur_tag = 7;
    int unsigned seed = 32'h1234_5678;

    typedef struct { int v; int sof; int eol; int pix; int tag; } exp_t;
    exp_t expq[$];

    // reference model state (behavioural)
    int m_row = 0, m_col = 0, m_sep = 1, m_res = 0;
    int m_gain[4] = '{0, 0, 0, 0};
    int m_ofs[4]  = '{0, 0, 0, 0};

    function automatic string tname(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  default: return "R8";
        endcase
    endfunction

    function automatic int sx8(logic [7:0] v);
        return v[7] ? int'(v) - 256 : int'(v);
    endfunction

    function automatic int rnd_pix();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % 1024);
    endfunction

    task automatic check(exp_t e);
        total++;
        if (out_valid !== e.v[0] || out_sof !== e.sof[0] || out_eol !== e.eol[0]
            || int'(out_pix) != e.pix) begin
            bad++;
            $display("FAIL %s: got v=%0b sof=%0b eol=%0b pix=%0d expected v=%0d sof=%0d eol=%0d pix=%0d",
                     tname(e.tag), out_valid, out_sof, out_eol, out_pix, e.v, e.sof, e.eol, e.pix);
        end
    endtask

    task automatic step(int v, int s, int e, int p);
        exp_t x;
        int ch, g;
        @(negedge clk);
        check(expq.pop_front());
        x.v = v; x.sof = v & s; x.eol = v & e; x.pix = 0; x.tag = cur_tag;
        if (v != 0) begin
            if (s != 0) begin
                m_gain = '{int'(g_r), int'(g_gr), int'(g_gb), int'(g_b)};
                m_ofs  = '{sx8(o_r), sx8(o_gr), sx8(o_gb), sx8(o_b)};
                m_sep  = int'(sep); m_res = int'(res);
                m_row = 0; m_col = 0;
            end
            ch = (m_sep != 0) ? (m_row * 2 + m_col) : 1;
            g  = (p * 128) / (128 - m_gain[ch]) + m_ofs[ch];
            if (g < 0) g = 0;
            if (g > 1023) g = 1023;
            if (m_res == 1) g = g & ~1;
            if (m_res == 2) g = g & ~3;
            x.pix = g;
            if (e != 0) begin m_row ^= 1; m_col = 0; end
            else m_col ^= 1;
        end
        expq.push_back(x);
        in_valid = v[0]; in_sof = s[0]; in_eol = e[0]; in_pix = p[9:0];
    endtask

    // one line; fixed < 0 means random pixels; gaps inserts idle cycles
    task automatic line(int cols, int first, int fixed, int gaps);
        for (int c = 0; c < cols; c++) begin
            if (gaps != 0 && (c % 3) == 1) step(0, 0, 0, 0);
            step(1, (first != 0 && c == 0) ? 1 : 0, (c == cols - 1) ? 1 : 0,
                 (fixed < 0) ? rnd_pix() : fixed);
        end
    endtask

    task automatic frame(int rows, int cols, int fixed, int gaps);
        for (int r = 0; r < rows; r++) line(cols, (r == 0) ? 1 : 0, fixed, gaps);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: outputs held at 0 during reset
        repeat (3) begin
            @(negedge clk);
            total++;
            if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_eol !== 1'b0 || out_pix !== '0) begin
                bad++;
                $display("FAIL R8: got v=%0b pix=%0d expected v=0 pix=0", out_valid, out_pix);
            end
        end
        rst_n = 1'b1;
        repeat (3) expq.push_back('{0, 0, 0, 0, 8});

        // R8: before any frame start, reset settings pass pixels unchanged
        cur_tag = 8;
        g_r = 7'd100; g_gr = 7'd50; o_b = 8'd40;
        line(6, 0, -1, 0);
        line(5, 0, -1, 1);

        // R1: distinct per-channel gain and offset, separation on
        cur_tag = 1;
        g_r = 7'd0; g_gr = 7'd32; g_gb = 7'd64; g_b = 7'd96;
        o_r = 8'd3; o_gr = 8'd10; o_gb = 8'hF6; o_b = 8'd0; sep = 1'b1;
        frame(4, 6, -1, 0);
        frame(3, 5, 200, 1);
        line(1, 1, 300, 0);   // single-pixel frame/line
        line(3, 0, 300, 0);

        // R2: separation off, green-R settings everywhere
        cur_tag = 2;
        sep = 1'b0; g_gr = 7'd40; o_gr = 8'd7;
        frame(4, 6, -1, 1);

        // R3: gain law corners (code 0, 64, 127)
        cur_tag = 3;
        sep = 1'b1; o_r = 0; o_gr = 0; o_gb = 0; o_b = 0;
        g_r = 7'd0; g_gr = 7'd64; g_gb = 7'd127; g_b = 7'd1;
        frame(2, 4, 5, 0);
        frame(2, 4, 1023, 0);
        frame(2, 4, 1, 0);
        frame(4, 8, -1, 0);
        g_r = 7'd127; g_gr = 7'd126; g_gb = 7'd3; g_b = 7'd77;
        frame(4, 8, -1, 0);

        // R4: signed offsets with saturation at both ends
        cur_tag = 4;
        g_r = 7'd0; g_gr = 7'd0; g_gb = 7'd20; g_b = 7'd0;
        o_r = 8'h80; o_gr = 8'd127; o_gb = 8'hFF; o_b = 8'h81;
        frame(2, 4, 0, 0);
        frame(2, 4, 1000, 0);
        frame(4, 6, -1, 0);

        // R5: precision select 1, 2, 3
        cur_tag = 5;
        o_r = 8'd1; o_gr = 8'd0; o_gb = 8'd2; o_b = 8'd3; g_gb = 7'd5;
        res = 2'd1; frame(3, 6, -1, 0);
        res = 2'd2; frame(3, 6, -1, 0);
        res = 2'd3; frame(3, 6, -1, 0);
        res = 2'd2; frame(2, 4, 1023, 0);

        // R6: mid-frame changes ignored until next start of frame
        cur_tag = 6;
        res = 2'd0; g_r = 7'd10; g_gr = 7'd20; o_r = 0; o_b = 0;
        line(6, 1, -1, 0);
        g_r = 7'd120; g_gr = 7'd0; g_b = 7'd90; o_gb = 8'd100; sep = 1'b0; res = 2'd2;
        line(6, 0, -1, 0);
        line(6, 0, -1, 1);
        frame(2, 6, -1, 0);   // new settings now active

        // R7: back-to-back frames, bubbles, then drain
        cur_tag = 7;
        sep = 1'b1; res = 2'd0;
        frame(2, 4, -1, 1);
        frame(2, 4, -1, 0);
        repeat (5) step(0, 0, 0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule